// File: doc/BRIEF.md
# USB Endpoint Multi-Channel DMA Engine

This block moves data between system memory and USB endpoint FIFOs on eight independent channels. Software reaches it through a small register bus. Each channel has a control word, a running address and a byte count, and all channels share one pending-interrupt register. Software loads the address and count first. A control write with the enable bit set then launches the channel. The channel issues one beat request at a time on the memory side until its byte budget is spent or the bus reports an error. It then clears its own enable bit and raises its pending bit.

The address register advances as beats complete, so software recovers the bytes moved as the final address minus the start address. A channel either runs one endpoint packet and stops, or runs the whole count as a continuous multi-packet transfer. The packet size comes from the `pkt_size` input at the moment of the start write. The two-bit burst hint in the control word passes to the memory side unchanged. When several channels want the bus, a fixed priority picks one of them.

Top module: `usb_ep_dma`

## Requirements
- R1: There are 8 channels. Channel n's registers sit at 0x200+16·n: the control word at +0x4 (bits 10:0 held, upper bits read zero), the 32-bit address at +0x8 and the 32-bit count at +0xC. An idle channel reads back what was written. Any other address reads zero.
- R2: The control word holds the enable (bit 0), the direction (bit 1, 1 = memory to endpoint, shown on `mem_from_mem`), multi-packet mode (bit 2), interrupt enable (bit 3), the endpoint number (bits 7:4, shown on `mem_ep`), the bus-error flag (bit 8) and the burst hint (bits 10:9, shown on `mem_burst`). The hint codes are 0 = unspecified, 1 = 4-beat, 2 = 8-beat and 3 = 16-beat incrementing.
- R3: A control write with bit 0 set starts the channel. `mem_req` is high in the cycle after that write.
- R4: Each accepted beat (`mem_req`, `mem_gnt` and not `mem_err`) moves min(remaining budget, BEAT_BYTES) bytes, shown on `mem_bytes`. The address goes up by that amount and the count goes down by it. The count never grows except by a register write.
- R5: With bit 2 set and count ≥ `pkt_size`, the budget is the whole count. Otherwise the budget is min(count, `pkt_size`), and the count keeps the remainder afterwards.
- R6: When the last beat is accepted, enable clears and pending bit n sets on the same edge. A start with a zero budget completes one cycle later and never requests the bus.
- R7: A beat accepted with `mem_err` leaves the address and count unchanged. It sets bit 8, clears bit 0 and sets the channel's pending bit.
- R8: Writing 0 to the control word of an active channel stops it: it makes no more requests and sets no pending bit. Its address and count can then be written with zero.
- R9: Of the channels that are requesting, the lowest-numbered one drives `mem_chan`, `mem_addr` and the other beat outputs. An unaccepted request stays the same.
- R10: A read of 0x200 returns the pending bits, with bit n belonging to channel n, and clears the bits it returned. A bit set on that same edge stays set.
- R11: `irq` is high when any pending channel has control bit 3 set.
- R12: After reset every register is zero, `mem_req` is low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears pending bits on a status read) |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pkt_size | input | PKT_W | Endpoint packet size, sampled at a start write |
| mem_req | output | 1 | Beat request |
| mem_addr | output | 32 | Beat address |
| mem_bytes | output | $clog2(BEAT_BYTES+1) | Bytes in this beat |
| mem_from_mem | output | 1 | 1 = read memory toward the endpoint |
| mem_burst | output | 2 | Burst-length hint |
| mem_ep | output | 4 | Endpoint number of the served channel |
| mem_chan | output | 3 | Served channel |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_err | input | 1 | The accepted beat failed |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that software does not write a channel's registers while that channel is moving data. The address-step and error checks are gated off in cycles with a register write. They also assume that `mem_err` means something only together with `mem_gnt` on a pending request. The stimulus keeps to this. It changes only stopped channels, or writes zero to stop one, and it raises an error only while a single stalled channel is requesting. Grants otherwise arrive at a random rate, including fully stalled and fully open stretches. A behavioural model is compared with the beat outputs and `irq` on every clock.

// File: rtl/usb_ep_dma.sv
module usb_ep_dma #(
  parameter int BEAT_BYTES = 4,
  parameter int PKT_W      = 11
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_wr,
  input  logic                              reg_rd,
  input  logic [9:0]                        reg_addr,
  input  logic [31:0]                       reg_wdata,
  output logic [31:0]                       reg_rdata,
  input  logic [PKT_W-1:0]                  pkt_size,
  output logic                              mem_req,
  output logic [31:0]                       mem_addr,
  output logic [$clog2(BEAT_BYTES+1)-1:0]   mem_bytes,
  output logic                              mem_from_mem,
  output logic [1:0]                        mem_burst,
  output logic [3:0]                        mem_ep,
  output logic [2:0]                        mem_chan,
  input  logic                              mem_gnt,
  input  logic                              mem_err,
  output logic                              irq
);
  localparam int NCH = 8;
  localparam int CW  = $clog2(NCH);
  localparam int BW  = $clog2(BEAT_BYTES+1);
  localparam logic [9:0] STAT_ADDR = 10'h200;
  localparam logic [31:0] BEAT32 = 32'(BEAT_BYTES);

  logic [10:0]    ctrl   [NCH];
  logic [31:0]    addr_q [NCH];
  logic [31:0]    cnt_q  [NCH];
  logic [31:0]    lim_q  [NCH];
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] req_vec, ie_vec, done_set;
  logic [CW-1:0]  win;
  logic [31:0]    step32;

  wire          in_win = reg_addr[9:7] == 3'b100;
  wire [CW-1:0] sel_ch = reg_addr[6:4];
  wire [3:0]    off    = reg_addr[3:0];
  wire          take   = mem_req && mem_gnt;
  wire          ok_beat = take && !mem_err;
  wire [NCH-1:0] rd_clr = (reg_rd && reg_addr == STAT_ADDR) ? pend_q : '0;

  function automatic logic [31:0] budget(input logic [31:0] c, input logic [PKT_W-1:0] p,
                                         input logic multi);
    logic [31:0] p32;
    p32 = 32'(p);
    if (multi && c >= p32) return c;
    return (c < p32) ? c : p32;
  endfunction

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      req_vec[i] = ctrl[i][0] && (lim_q[i] != 0);
      ie_vec[i]  = ctrl[i][3];
    end
    win = '0;
    for (int i = NCH-1; i >= 0; i--)
      if (req_vec[i]) win = CW'(i);
  end

  assign step32       = (lim_q[win] < BEAT32) ? lim_q[win] : BEAT32;
  assign mem_req      = |req_vec;
  assign mem_addr     = addr_q[win];
  assign mem_bytes    = step32[BW-1:0];
  assign mem_from_mem = ctrl[win][1];
  assign mem_burst    = ctrl[win][10:9];
  assign mem_ep       = ctrl[win][7:4];
  assign mem_chan     = win;
  assign irq          = |(pend_q & ie_vec);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      done_set[i] = !(reg_wr && in_win && sel_ch == CW'(i) && off == 4'h4) && ctrl[i][0] &&
                    (lim_q[i] == 0 ||
                     (take && win == CW'(i) && (mem_err || step32 == lim_q[i])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        ctrl[i]   <= '0;
        addr_q[i] <= '0;
        cnt_q[i]  <= '0;
        lim_q[i]  <= '0;
      end
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_wr && in_win && sel_ch == CW'(i) && off == 4'h4) begin
          ctrl[i]  <= reg_wdata[10:0];
          lim_q[i] <= reg_wdata[0] ? budget(cnt_q[i], pkt_size, reg_wdata[2]) : '0;
        end else begin
          if (done_set[i]) begin
            ctrl[i][0] <= 1'b0;
            if (take && win == CW'(i) && mem_err) ctrl[i][8] <= 1'b1;
          end
          if (ok_beat && win == CW'(i)) lim_q[i] <= lim_q[i] - step32;
        end
        if (reg_wr && in_win && sel_ch == CW'(i) && off == 4'h8)
          addr_q[i] <= reg_wdata;
        else if (ok_beat && win == CW'(i))
          addr_q[i] <= addr_q[i] + step32;
        if (reg_wr && in_win && sel_ch == CW'(i) && off == 4'hC)
          cnt_q[i] <= reg_wdata;
        else if (ok_beat && win == CW'(i))
          cnt_q[i] <= cnt_q[i] - step32;
      end
      pend_q <= (pend_q & ~rd_clr) | done_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == STAT_ADDR)
      reg_rdata = {{(32-NCH){1'b0}}, pend_q};
    else if (in_win) begin
      case (off)
        4'h4:    reg_rdata = {21'b0, ctrl[sel_ch]};
        4'h8:    reg_rdata = addr_q[sel_ch];
        4'hC:    reg_rdata = cnt_q[sel_ch];
        default: reg_rdata = '0;
      endcase
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_err && !reg_wr) |=>
      addr_q[$past(mem_chan)] == $past(mem_addr) + 32'($past(mem_bytes)));

  // R7
  bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_err && !reg_wr) |=>
      (pend_q[$past(mem_chan)] && ctrl[$past(mem_chan)][8] && !ctrl[$past(mem_chan)][0]));

  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !reg_wr) |=>
      (mem_req && mem_chan == $past(mem_chan) && $stable(mem_addr)));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_cnt
      // R4
      cnt_nogrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> cnt_q[g] <= $past(cnt_q[g]));
    end
  endgenerate
endmodule

// File: tb/usb_ep_dma_test.sv
module usb_ep_dma_test;
  localparam int BEAT = 4;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [10:0] pkt_size = 11'd64;
  logic mem_req, mem_from_mem, mem_gnt = 0, mem_err = 0, irq;
  logic [31:0] mem_addr;
  logic [2:0] mem_bytes, mem_chan;
  logic [1:0] mem_burst;
  logic [3:0] mem_ep;

  int errors = 0, checks = 0, cycles = 0, gnt_pct = 70;
  bit err_req = 0;

  int unsigned m_ctrl[8], m_addr[8], m_cnt[8], m_lim[8];
  bit [7:0] m_pend;

  usb_ep_dma uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pkt_size(pkt_size),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_from_mem(mem_from_mem),
    .mem_burst(mem_burst), .mem_ep(mem_ep), .mem_chan(mem_chan), .mem_gnt(mem_gnt),
    .mem_err(mem_err), .irq(irq));

  always #2 clk = ~clk;

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic int m_win();
    for (int i = 0; i < 8; i++)
      if ((m_ctrl[i] & 1) != 0 && m_lim[i] != 0) return i;
    return -1;
  endfunction

  function automatic int unsigned m_budget(int unsigned c, int unsigned p, bit multi);
    if (multi && c >= p) return c;
    return (c < p) ? c : p;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_ctrl[i] = 0; m_addr[i] = 0; m_cnt[i] = 0; m_lim[i] = 0; end
      m_pend = 0;
    end else begin
      int w;
      int unsigned st;
      bit take, wwin;
      bit [7:0] setv, clr;
      w = m_win();
      st = (w >= 0) ? ((m_lim[w] < BEAT) ? m_lim[w] : BEAT) : 0;
      take = (w >= 0) && mem_gnt;
      wwin = reg_wr && reg_addr[9:7] == 3'b100;
      clr = (reg_rd && reg_addr == 10'h200) ? m_pend : 8'h0;
      setv = 0;
      for (int i = 0; i < 8; i++) begin
        bit me;
        me = take && w == i;
        if (wwin && reg_addr[6:4] == i && reg_addr[3:0] == 4) begin
          m_ctrl[i] = reg_wdata & 32'h7FF;
          m_lim[i] = reg_wdata[0] ? m_budget(m_cnt[i], pkt_size, reg_wdata[2]) : 0;
        end else if ((m_ctrl[i] & 1) != 0) begin
          if (m_lim[i] == 0) begin m_ctrl[i] &= ~32'h1; setv[i] = 1; end
          else if (me && mem_err) begin m_ctrl[i] = (m_ctrl[i] | 32'h100) & ~32'h1; setv[i] = 1; end
          else if (me) begin
            m_lim[i] -= st;
            if (m_lim[i] == 0) begin m_ctrl[i] &= ~32'h1; setv[i] = 1; end
          end
        end
        if (wwin && reg_addr[6:4] == i && reg_addr[3:0] == 8) m_addr[i] = reg_wdata;
        else if (me && !mem_err) m_addr[i] += st;
        if (wwin && reg_addr[6:4] == i && reg_addr[3:0] == 12) m_cnt[i] = reg_wdata;
        else if (me && !mem_err) m_cnt[i] -= st;
      end
      m_pend = (m_pend & ~clr) | setv;
    end
  end

  // per-cycle comparison late in each cycle (R2 R4 R9 R11)
  always begin
    @(posedge clk); #3;
    if (rst_n) begin
      int w;
      bit [7:0] ie;
      w = m_win();
      for (int i = 0; i < 8; i++) ie[i] = m_ctrl[i][3];
      check("R11 irq vs model", irq, |(m_pend & ie));
      check("R9 mem_req vs model", mem_req, w >= 0);
      if (w >= 0) begin
        check("R9 mem_chan vs model", mem_chan, w);
        check("R4 mem_addr vs model", mem_addr, m_addr[w]);
        check("R4 mem_bytes vs model", mem_bytes, (m_lim[w] < BEAT) ? m_lim[w] : BEAT);
        check("R2 mem_burst vs model", mem_burst, (m_ctrl[w] >> 9) & 3);
        check("R2 mem_ep vs model", mem_ep, (m_ctrl[w] >> 4) & 15);
        check("R2 mem_from_mem vs model", mem_from_mem, (m_ctrl[w] >> 1) & 1);
      end
    end
  end

  always @(negedge clk) begin
    if (err_req) begin mem_gnt = 1; mem_err = 1; err_req = 0; end
    else begin mem_err = 0; mem_gnt = ($urandom % 100) < gnt_pct; end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rchk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic wait_idle(input int ch);
    for (int k = 0; k < 2000 && (m_ctrl[ch] & 1) != 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [9:0] ra(input int ch, input int o);
    return 10'(32'h200 + 16 * ch + o);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 mem_req after reset", mem_req, 0);
    check("R12 irq after reset", irq, 0);
    rchk("R12 status after reset", 10'h200, 0);
    rchk("R12 ch6 addr after reset", ra(6, 8), 0);

    wr(ra(3, 8), 32'h1000_0040); wr(ra(3, 12), 32'h123); wr(ra(3, 4), 32'hFFFF_F0F0);
    rchk("R1 ch3 addr readback", ra(3, 8), 32'h1000_0040);
    rchk("R1 ch3 count readback", ra(3, 12), 32'h123);
    rchk("R1 ch3 ctrl readback", ra(3, 4), 32'h0F0);
    rchk("R1 unmapped offset", ra(3, 0), 0);

    wr(ra(0, 8), 32'h1000); wr(ra(0, 12), 100);
    wr(ra(0, 4), 32'h65F);
    check("R3 request after start", mem_req, 1);
    check("R2 burst hint 16-beat", mem_burst, 3);
    check("R2 endpoint field", mem_ep, 5);
    check("R2 direction", mem_from_mem, 1);
    wait_idle(0);
    check("R11 irq with enable", irq, 1);
    rchk("R5 multi-packet address", ra(0, 8), 32'h1064);
    rchk("R4 count used up", ra(0, 12), 0);
    rchk("R6 enable cleared", ra(0, 4), 32'h65E);
    rchk("R10 status shows ch0", 10'h200, 32'h01);
    rchk("R10 status cleared by read", 10'h200, 0);
    check("R11 irq after clear", irq, 0);

    wr(ra(1, 8), 32'h2000); wr(ra(1, 12), 40); wr(ra(1, 4), 32'h2D);
    wait_idle(1);
    rchk("R5 short count falls back to one packet", ra(1, 8), 32'h2028);
    rchk("R10 ch1 pending", 10'h200, 32'h02);

    wr(ra(1, 8), 32'h3000); wr(ra(1, 12), 200); wr(ra(1, 4), 32'h29);
    wait_idle(1);
    rchk("R5 single packet address", ra(1, 8), 32'h3040);
    rchk("R5 single packet remainder", ra(1, 12), 136);
    rchk("R10 ch1 pending again", 10'h200, 32'h02);

    wr(ra(1, 8), 32'h3800); wr(ra(1, 12), 8); wr(ra(1, 4), 32'h21);
    wait_idle(1);
    check("R11 no irq when disabled", irq, 0);
    rchk("R11 pending still recorded", 10'h200, 32'h02);

    gnt_pct = 0;
    wr(ra(5, 8), 32'h5000); wr(ra(5, 12), 32); wr(ra(5, 4), 32'h201);
    wr(ra(2, 8), 32'h4000); wr(ra(2, 12), 16); wr(ra(2, 4), 32'h401);
    repeat (2) @(negedge clk);
    check("R9 lowest channel wins", mem_chan, 2);
    check("R9 winner address", mem_addr, 32'h4000);
    check("R2 burst hint 8-beat", mem_burst, 2);
    gnt_pct = 100;
    wait_idle(2); wait_idle(5);
    rchk("R9 ch2 done", ra(2, 8), 32'h4010);
    rchk("R9 ch5 done", ra(5, 8), 32'h5020);
    rchk("R10 two pending", 10'h200, 32'h24);
    gnt_pct = 70;

    gnt_pct = 0;
    wr(ra(4, 8), 32'h6000); wr(ra(4, 12), 64); wr(ra(4, 4), 32'h9);
    err_req = 1;
    repeat (4) @(negedge clk);
    rchk("R7 error flag set, enable cleared", ra(4, 4), 32'h108);
    rchk("R7 address unchanged", ra(4, 8), 32'h6000);
    rchk("R7 count unchanged", ra(4, 12), 64);
    rchk("R7 pending on error", 10'h200, 32'h10);

    wr(ra(6, 8), 32'h7000); wr(ra(6, 12), 64); wr(ra(6, 4), 32'h9);
    check("R8 channel running", mem_req, 1);
    wr(ra(6, 4), 0);
    gnt_pct = 70;
    repeat (6) @(negedge clk);
    check("R8 no request after stop", mem_req, 0);
    rchk("R8 no pending after stop", 10'h200, 0);
    wr(ra(6, 8), 0); wr(ra(6, 12), 0);
    rchk("R8 address zeroed", ra(6, 8), 0);
    rchk("R8 count zeroed", ra(6, 12), 0);

    wr(ra(7, 4), 32'h9);
    check("R6 zero budget makes no request", mem_req, 0);
    @(negedge clk);
    check("R6 zero budget irq", irq, 1);
    rchk("R6 zero budget pending", 10'h200, 32'h80);

    gnt_pct = 50;
    for (int r = 0; r < 20; r++) begin
      wr(ra(r % 8, 8), 32'h8000 + 32'(r) * 256);
      wr(ra(r % 8, 12), 32'(r * 7 + 3));
      wr(ra(r % 8, 4), 32'h1 | 32'h4 | 32'((r % 4) << 9));
      wait_idle(r % 8);
      rchk("R4 address after mixed run", ra(r % 8, 8),
           32'h8000 + 32'(r) * 256 + ((r * 7 + 3 >= 64) ? r * 7 + 3 : ((r * 7 + 3 < 64) ? r * 7 + 3 : 64)));
    end
    rchk("R10 read mixed pending", 10'h200, m_pend);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule